// File: doc/BRIEF.md
# Burst Request to Memory Command Adapter

This block sits between an AXI-style master and a memory back end. The master uses a single address channel for both directions, with a direction flag on each request. The adapter turns each accepted request into one burst command for the back end. The command carries the start address, the beat count, the beat size, a wrap indication, the total byte span and the aligned wrap base.

Once the back end has taken the command, the adapter relays traffic in both directions:

- **Write:** it passes write beats and byte strobes through to the back end, then returns a write response.
- **Read:** it passes back-end read beats to the master, marks the final beat, and echoes the request ID.

Only one transaction is in flight at a time. A new request is taken only after the previous one has fully finished, so completion order always equals request order.

Top module: `axi_burst_cmd_adapter`

## Requirements
- R1: A request with `arw_write` = 1 yields a command with `cmd_write` = 1 followed by a write-data phase. A request with `arw_write` = 0 yields `cmd_write` = 0 followed by a read-data phase.
- R2: `cmd_beats` equals `arw_len` + 1, giving 1 to 256 beats. Both `r_last` and `be_wlast` are high on exactly the beat numbered `arw_len` (counting from 0) and low on every earlier beat.
- R3: Burst code 2'b01 gives a linear command (`cmd_wrap` = 0). Codes 2'b00 and 2'b10 both give a wrap command (`cmd_wrap` = 1). The reserved code 2'b11 is handled as linear.
- R4: `cmd_size` repeats `arw_size`, where a beat holds 1 << size bytes. `cmd_span` = (`arw_len` + 1) << `arw_size` bytes. For wrap commands, `cmd_base` is the start address with its low bits cleared so that it is aligned to `cmd_span`; wrap beat counts must be powers of two. For linear commands, `cmd_base` equals `cmd_addr`.
- R5: Address bit 31 is treated as zero: `cmd_addr[31]` and `cmd_base[31]` are always 0, whatever value `arw_addr[31]` holds.
- R6: Read beats reach `r_data` in the order the back end delivers them. `r_id` equals the request ID and `r_resp` is always 2'b00.
- R7: Write data and strobes reach `be_wdata` and `be_wstrb` unchanged and in order. After the last beat, `b_valid` rises with `b_id` equal to the request ID and `b_resp` = 2'b00.
- R8: `arw_ready` is low from the accepted request until the final handshake of that transaction: the `b_valid`/`b_ready` handshake for a write, or the last-beat `r_valid`/`r_ready` handshake for a read. It is high again in the following cycle.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and every command field hold their values.
- R10: After reset, `arw_ready` is 1 and `cmd_valid`, `b_valid`, `r_valid`, `be_wvalid` and `be_rready` are 0.
- R11: Backpressure loses and duplicates nothing. With `be_wready` low, `w_ready` is low. With `r_ready` low, `be_rready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arw_valid | input | 1 | Request valid |
| arw_ready | output | 1 | Request accepted when high with valid |
| arw_addr | input | 32 | Start byte address, bit 31 ignored |
| arw_id | input | 8 | Request ID |
| arw_len | input | 8 | Beats minus one |
| arw_size | input | 3 | log2 of bytes per beat |
| arw_burst | input | 2 | Burst code |
| arw_write | input | 1 | 1 write, 0 read |
| w_valid | input | 1 | Write beat valid |
| w_ready | output | 1 | Write beat accepted |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Master's last-beat flag |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response accepted |
| b_id | output | 8 | Echoed request ID |
| b_resp | output | 2 | Always OKAY |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat accepted |
| r_data | output | DATA_W | Read data |
| r_id | output | 8 | Echoed request ID |
| r_resp | output | 2 | Always OKAY |
| r_last | output | 1 | Final read beat |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command taken |
| cmd_write | output | 1 | Command direction |
| cmd_addr | output | 32 | Start address |
| cmd_base | output | 32 | Wrap base address |
| cmd_beats | output | 9 | Beat count |
| cmd_size | output | 3 | log2 bytes per beat |
| cmd_wrap | output | 1 | Wrap burst |
| cmd_span | output | 16 | Total bytes of the burst |
| be_wvalid | output | 1 | Back-end write beat valid |
| be_wready | input | 1 | Back-end write beat taken |
| be_wdata | output | DATA_W | Back-end write data |
| be_wstrb | output | DATA_W/8 | Back-end strobes |
| be_wlast | output | 1 | Final write beat |
| be_rvalid | input | 1 | Back-end read beat valid |
| be_rready | output | 1 | Back-end read beat taken |
| be_rdata | input | DATA_W | Back-end read data |

## Verification
Random requests cover mixed directions, lengths, sizes, burst codes and addresses with bit 31 set at random. This exposes mistakes in beat counting, span arithmetic and the burst-code mapping.

Directed cases target specific corners:

- A single-beat read and a 256-beat, 128-byte linear burst, which separate off-by-one errors in the last-beat flag and overflow of the span.
- Wrap requests with codes 2'b00 and 2'b10 at unaligned addresses, which separate correct base alignment from a plain copy of the address.
- Code 2'b11, which distinguishes linear handling from wrap handling.

Random stalls on the command, data and response channels show that beats are neither dropped nor repeated, and that a new request stays blocked until the final handshake.

// File: rtl/abca_pkg.sv
package abca_pkg;

    localparam int ADDR_W  = 32;
    localparam int ID_W    = 8;
    localparam int LEN_W   = 8;
    localparam int BEATS_W = LEN_W + 1;
    localparam int SPAN_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDAT,
        ST_RDAT,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic              write;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [2:0]        size;
        logic [1:0]        burst;
    } req_t;

    typedef struct packed {
        logic               write;
        logic [ADDR_W-1:0]  addr;
        logic [ADDR_W-1:0]  base;
        logic [BEATS_W-1:0] beats;
        logic [2:0]         size;
        logic               wrap;
        logic [SPAN_W-1:0]  span;
    } cmd_t;

    // 2'b00 and 2'b10 wrap; 2'b01 and reserved 2'b11 run linear
    function automatic logic burst_is_wrap(input logic [1:0] code);
        return (code == 2'b00) || (code == 2'b10);
    endfunction

    function automatic logic [SPAN_W-1:0] span_bytes(input logic [BEATS_W-1:0] beats,
                                                     input logic [2:0] size);
        logic [SPAN_W-1:0] wide;
        wide = {{(SPAN_W-BEATS_W){1'b0}}, beats};
        return wide << size;
    endfunction

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                     input logic [SPAN_W-1:0] span);
        logic [ADDR_W-1:0] mask;
        mask = {{(ADDR_W-SPAN_W){1'b0}}, span - 1'b1};
        return a & ~mask;
    endfunction

endpackage

// File: rtl/abca_decode.sv
module abca_decode
    import abca_pkg::*;
(
    input  req_t req,
    output cmd_t cmd
);

    logic [ADDR_W-1:0] start_addr;
    logic [SPAN_W-1:0] span;
    logic              wrap;

    always_comb begin
        start_addr = {1'b0, req.addr[ADDR_W-2:0]};
        wrap       = burst_is_wrap(req.burst);
        span       = span_bytes({1'b0, req.len} + 1'b1, req.size);

        cmd.write  = req.write;
        cmd.addr   = start_addr;
        cmd.beats  = {1'b0, req.len} + 1'b1;
        cmd.size   = req.size;
        cmd.wrap   = wrap;
        cmd.span   = span;
        cmd.base   = wrap ? align_down(start_addr, span) : start_addr;
    end

endmodule

// File: rtl/abca_beat_ctr.sv
module abca_beat_ctr
    import abca_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               step,
    input  logic [BEATS_W-1:0] beats,
    output logic               last
);

    logic [BEATS_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    assign last = (count == beats - 1'b1);

    // R2: the counter never passes the requested beat count
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
        count <= beats);

endmodule

// File: rtl/abca_ctrl.sv
module abca_ctrl
    import abca_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_fire,
    input  req_t   req_in,
    input  logic   cmd_fire,
    input  logic   wbeat_fire,
    input  logic   rbeat_fire,
    input  logic   beat_last,
    input  logic   resp_fire,
    output state_e state,
    output req_t   req_q
);

    state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_fire)                 nxt = ST_CMD;
            ST_CMD:  if (cmd_fire)                 nxt = req_q.write ? ST_WDAT : ST_RDAT;
            ST_WDAT: if (wbeat_fire && beat_last)  nxt = ST_RESP;
            ST_RDAT: if (rbeat_fire && beat_last)  nxt = ST_IDLE;
            ST_RESP: if (resp_fire)                nxt = ST_IDLE;
            default:                               nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
        end else begin
            state <= nxt;
            if (req_fire) req_q <= req_in;
        end
    end

    // R1: a write command leads to the write-data phase only
    a_r1_dir_phase: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD && cmd_fire) |=> (state == (req_q.write ? ST_WDAT : ST_RDAT)));

endmodule

// File: rtl/axi_burst_cmd_adapter.sv
module axi_burst_cmd_adapter
    import abca_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arw_valid,
    output logic               arw_ready,
    input  logic [31:0]        arw_addr,
    input  logic [7:0]         arw_id,
    input  logic [7:0]         arw_len,
    input  logic [2:0]         arw_size,
    input  logic [1:0]         arw_burst,
    input  logic               arw_write,
    input  logic               w_valid,
    output logic               w_ready,
    input  logic [DATA_W-1:0]  w_data,
    input  logic [STRB_W-1:0]  w_strb,
    input  logic               w_last,
    output logic               b_valid,
    input  logic               b_ready,
    output logic [7:0]         b_id,
    output logic [1:0]         b_resp,
    output logic               r_valid,
    input  logic               r_ready,
    output logic [DATA_W-1:0]  r_data,
    output logic [7:0]         r_id,
    output logic [1:0]         r_resp,
    output logic               r_last,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic               cmd_write,
    output logic [31:0]        cmd_addr,
    output logic [31:0]        cmd_base,
    output logic [8:0]         cmd_beats,
    output logic [2:0]         cmd_size,
    output logic               cmd_wrap,
    output logic [15:0]        cmd_span,
    output logic               be_wvalid,
    input  logic               be_wready,
    output logic [DATA_W-1:0]  be_wdata,
    output logic [STRB_W-1:0]  be_wstrb,
    output logic               be_wlast,
    input  logic               be_rvalid,
    output logic               be_rready,
    input  logic [DATA_W-1:0]  be_rdata
);

    state_e state;
    req_t   req_in, req_q;
    cmd_t   cmd;
    logic   beat_last;
    logic   req_fire, cmd_fire, wbeat_fire, rbeat_fire, resp_fire;

    always_comb begin
        req_in.write = arw_write;
        req_in.id    = arw_id;
        req_in.addr  = arw_addr;
        req_in.len   = arw_len;
        req_in.size  = arw_size;
        req_in.burst = arw_burst;
    end

    assign arw_ready  = (state == ST_IDLE);
    assign req_fire   = arw_valid && arw_ready;
    assign cmd_fire   = cmd_valid && cmd_ready;
    assign wbeat_fire = be_wvalid && be_wready;
    assign rbeat_fire = r_valid && r_ready;
    assign resp_fire  = b_valid && b_ready;

    abca_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_fire   (req_fire),
        .req_in     (req_in),
        .cmd_fire   (cmd_fire),
        .wbeat_fire (wbeat_fire),
        .rbeat_fire (rbeat_fire),
        .beat_last  (beat_last),
        .resp_fire  (resp_fire),
        .state      (state),
        .req_q      (req_q)
    );

    abca_decode u_decode (
        .req (req_q),
        .cmd (cmd)
    );

    abca_beat_ctr u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (req_fire),
        .step  (wbeat_fire || rbeat_fire),
        .beats (cmd.beats),
        .last  (beat_last)
    );

    // command channel
    assign cmd_valid = (state == ST_CMD);
    assign cmd_write = cmd.write;
    assign cmd_addr  = cmd.addr;
    assign cmd_base  = cmd.base;
    assign cmd_beats = cmd.beats;
    assign cmd_size  = cmd.size;
    assign cmd_wrap  = cmd.wrap;
    assign cmd_span  = cmd.span;

    // write relay
    assign be_wvalid = (state == ST_WDAT) && w_valid;
    assign w_ready   = (state == ST_WDAT) && be_wready;
    assign be_wdata  = w_data;
    assign be_wstrb  = w_strb;
    assign be_wlast  = beat_last;

    assign b_valid   = (state == ST_RESP);
    assign b_id      = req_q.id;
    assign b_resp    = 2'b00;

    // read relay
    assign r_valid   = (state == ST_RDAT) && be_rvalid;
    assign be_rready = (state == ST_RDAT) && r_ready;
    assign r_data    = be_rdata;
    assign r_id      = req_q.id;
    assign r_resp    = 2'b00;
    assign r_last    = beat_last;

    // R8: no new request while any part of a transaction is pending
    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || b_valid || r_valid) |-> !arw_ready);

    // R8: final read handshake frees the address channel
    a_r8_rlast_frees: assert property (@(posedge clk) disable iff (rst)
        (r_valid && r_ready && r_last) |=> arw_ready);

    // R7: final write beat leads to a response
    a_r7_wlast_to_resp: assert property (@(posedge clk) disable iff (rst)
        (be_wvalid && be_wready && be_wlast) |=> (b_valid && b_resp == 2'b00));

    // R9: command held while stalled
    a_r9_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_base)
                                       && $stable(cmd_beats) && $stable(cmd_span)
                                       && $stable(cmd_wrap) && $stable(cmd_write)));

    // R5: reserved address bit never reaches the back end
    a_r5_bit31_clear: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (!cmd_addr[31] && !cmd_base[31]));

    // R2: the master's last flag agrees with the beat count
    a_r2_wlast_agrees: assert property (@(posedge clk) disable iff (rst)
        (w_valid && w_ready) |-> (w_last == be_wlast));

    // R6: read response is always OKAY
    a_r6_okay: assert property (@(posedge clk) disable iff (rst)
        r_valid |-> (r_resp == 2'b00));

endmodule

// File: tb/axi_burst_cmd_adapter_tb_top.sv
`timescale 1ns/1ps
module axi_burst_cmd_adapter_tb_top;

    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    logic          arw_valid, arw_ready, arw_write;
    logic [31:0]   arw_addr;
    logic [7:0]    arw_id, arw_len;
    logic [2:0]    arw_size;
    logic [1:0]    arw_burst;
    logic          w_valid, w_ready, w_last;
    logic [DW-1:0] w_data;
    logic [SW-1:0] w_strb;
    logic          b_valid, b_ready;
    logic [7:0]    b_id;
    logic [1:0]    b_resp;
    logic          r_valid, r_ready, r_last;
    logic [DW-1:0] r_data;
    logic [7:0]    r_id;
    logic [1:0]    r_resp;
    logic          cmd_valid, cmd_ready, cmd_write, cmd_wrap;
    logic [31:0]   cmd_addr, cmd_base;
    logic [8:0]    cmd_beats;
    logic [2:0]    cmd_size;
    logic [15:0]   cmd_span;
    logic          be_wvalid, be_wready, be_wlast;
    logic [DW-1:0] be_wdata;
    logic [SW-1:0] be_wstrb;
    logic          be_rvalid, be_rready;
    logic [DW-1:0] be_rdata;

    axi_burst_cmd_adapter #(.DATA_W(DW)) dut_i (.*);

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_wrap(input logic [1:0] b);
        return (b == 2'b00) || (b == 2'b10);
    endfunction

    function automatic logic [15:0] exp_span(input logic [7:0] len, input logic [2:0] size);
        int s;
        s = (int'(len) + 1) * (1 << size);
        return s[15:0];
    endfunction

    function automatic logic [31:0] exp_base(input logic [31:0] a, input logic [7:0] len,
                                             input logic [2:0] size, input logic [1:0] b);
        logic [31:0] clean;
        int span;
        clean = a & 32'h7fff_ffff;
        span  = (int'(len) + 1) * (1 << size);
        if (!exp_wrap(b)) return clean;
        return clean - (clean % span);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic run_txn(input logic wr, input logic [31:0] addr, input logic [7:0] id,
                           input logic [7:0] len, input logic [2:0] size, input logic [1:0] burst);
        int beats;
        int b;
        logic [DW-1:0] d;
        logic [SW-1:0] s;
        beats = int'(len) + 1;
        #1;
        chk("R8 ready before request", arw_ready, 1'b1);
        arw_valid = 1; arw_write = wr; arw_addr = addr; arw_id = id;
        arw_len = len; arw_size = size; arw_burst = burst;
        tick();
        arw_valid = 0; arw_addr = $urandom; arw_len = $urandom;
        #1;
        chk("R8 busy after request", arw_ready, 1'b0);
        // command channel with random stall
        for (int k = 0; k < int'($urandom % 3); k++) begin
            chk("R9 cmd held", cmd_valid, 1'b1);
            tick(); #1;
        end
        chk("R9 cmd valid", cmd_valid, 1'b1);
        chk("R1 direction", cmd_write, wr);
        chk("R5 addr bit31 cleared", cmd_addr, addr & 32'h7fff_ffff);
        chk("R2 beat count", cmd_beats, beats);
        chk("R3 wrap flag", cmd_wrap, exp_wrap(burst));
        chk("R4 size", cmd_size, size);
        chk("R4 span", cmd_span, exp_span(len, size));
        chk("R4 wrap base", cmd_base, exp_base(addr, len, size, burst));
        cmd_ready = 1;
        tick();
        cmd_ready = 0;
        if (wr) begin
            b = 0;
            while (b < beats) begin
                d = $urandom; s = $urandom;
                w_valid = ($urandom % 5) != 0;
                w_data = d; w_strb = s; w_last = (b == beats - 1);
                be_wready = ($urandom % 4) != 0;
                #1;
                chk("R11 w_ready follows back end", w_ready, be_wready);
                chk("R1 write phase valid", be_wvalid, w_valid);
                if (w_valid && be_wready) begin
                    chk("R7 write data", be_wdata, d);
                    chk("R7 write strobe", be_wstrb, s);
                    chk("R2 write last", be_wlast, (b == beats - 1));
                    b++;
                end
                tick();
            end
            w_valid = 0; be_wready = 0; w_last = 0;
            #1;
            for (int k = 0; k < int'($urandom % 3); k++) begin
                chk("R7 resp pending", b_valid, 1'b1);
                chk("R8 busy during resp", arw_ready, 1'b0);
                tick(); #1;
            end
            chk("R7 resp valid", b_valid, 1'b1);
            chk("R7 resp id", b_id, id);
            chk("R7 resp okay", b_resp, 2'b00);
            b_ready = 1;
            tick();
            b_ready = 0;
        end else begin
            b = 0;
            while (b < beats) begin
                d = {id, 8'hA5, b[15:0]} ^ DW'(addr);
                be_rvalid = ($urandom % 5) != 0;
                be_rdata = d;
                r_ready = ($urandom % 4) != 0;
                #1;
                chk("R11 back-end ready follows master", be_rready, r_ready);
                chk("R1 read phase valid", r_valid, be_rvalid);
                chk("R8 busy during read", arw_ready, 1'b0);
                if (be_rvalid && r_ready) begin
                    chk("R6 read data", r_data, d);
                    chk("R6 read id", r_id, id);
                    chk("R6 read okay", r_resp, 2'b00);
                    chk("R2 read last", r_last, (b == beats - 1));
                    b++;
                end
                tick();
            end
            be_rvalid = 0; r_ready = 0;
        end
        #1;
        chk("R8 free after final handshake", arw_ready, 1'b1);
        tick();
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst = 1;
        arw_valid = 0; arw_write = 0; arw_addr = 0; arw_id = 0; arw_len = 0;
        arw_size = 0; arw_burst = 0;
        w_valid = 0; w_data = 0; w_strb = 0; w_last = 0;
        b_ready = 0; r_ready = 0; cmd_ready = 0;
        be_wready = 0; be_rvalid = 0; be_rdata = 0;
        repeat (3) tick();
        #1;
        chk("R10 reset arw_ready", arw_ready, 1'b1);
        chk("R10 reset cmd_valid", cmd_valid, 1'b0);
        chk("R10 reset b_valid", b_valid, 1'b0);
        chk("R10 reset r_valid", r_valid, 1'b0);
        chk("R10 reset be_wvalid", be_wvalid, 1'b0);
        chk("R10 reset be_rready", be_rready, 1'b0);
        rst = 0;
        tick();
        // directed corners
        run_txn(1'b0, 32'h0000_1004, 8'h11, 8'd0,   3'd2, 2'b01);
        run_txn(1'b0, 32'h8000_2000, 8'h22, 8'd255, 3'd7, 2'b01);
        run_txn(1'b1, 32'h8000_0134, 8'h33, 8'd3,   3'd2, 2'b00);
        run_txn(1'b0, 32'h0000_07A8, 8'h44, 8'd15,  3'd3, 2'b10);
        run_txn(1'b1, 32'h0000_0ABC, 8'h55, 8'd7,   3'd2, 2'b11);
        run_txn(1'b0, 32'h0000_0ABC, 8'h66, 8'd1,   3'd0, 2'b11);
        run_txn(1'b1, 32'h0123_4567, 8'h77, 8'd0,   3'd0, 2'b01);
        // random mix
        for (int t = 0; t < 60; t++) begin
            logic [1:0] bu;
            logic [7:0] ln;
            bu = $urandom;
            if (exp_wrap(bu)) ln = 8'((1 << ($urandom % 5)) - 1);
            else              ln = 8'($urandom % 24);
            run_txn(1'($urandom), $urandom, 8'($urandom), ln, 3'($urandom), bu);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule